// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight raw interrupt lines into a vector of pending requests. Each line is either level-sensitive or edge-sensitive, selected by a per-line trigger-mode register. A level-sensitive request tracks its line. An edge-sensitive request is armed by a low-to-high transition and then stays set until it is acknowledged. To find that transition, the block stores the previous level of every line.

The request vector goes to a priority resolver, which is outside this block. That resolver acknowledges the line it services by giving an index. Mask bits come in from outside only so that a per-line status code can be produced; they never change the request vector. An initialise pulse returns the edge-sensitive side to a clean state and keeps level-sensitive requests. The writable bits of the trigger-mode register are fixed per instance by a parameter: 0xF8 for a primary instance and 0xDE for a secondary one.

Top module: `irq_req_latch`

## Requirements
- R1: While `rst_ni` is low, the request vector, the stored previous levels, the trigger-mode register and every status code are cleared.
- R2: For a level-sensitive line (trigger bit 1), the request bit after a clock edge equals the line level sampled at that edge.
- R3: For an edge-sensitive line (trigger bit 0), the request bit is set at an edge where the line is high and its stored previous level is low. The previous level is updated to the line value at every edge outside initialise.
- R4: For an edge-sensitive line, a falling line or a line held high leaves the request bit unchanged.
- R5: An acknowledge (`ack_valid_i` with the binary line number on `ack_idx_i`) clears an edge-sensitive request bit. It has no effect on a level-sensitive bit.
- R6: When an acknowledge and a rising edge hit the same edge-sensitive line in one cycle, the acknowledge is applied first, so the request bit ends up set.
- R7: A trigger-mode write stores `trig_wdata_i & WMASK`. Bits outside `WMASK` (default 0xF8) always read 0. The write takes effect from the following cycle.
- R8: An initialise pulse clears every stored previous level and every edge-sensitive request bit, keeps level-sensitive request bits, and ignores line events in that cycle. An edge-sensitive line still high afterwards raises a new request.
- R9: The status code of line i is on `status_o[2i+1:2i]` and is registered. It is 2'b11 if the mask bit was set. Otherwise it is 2'b01 if a line event newly raised a request that was not pending after the acknowledge step, and 2'b00 in every other case. Mask bits never alter the request vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| line_i | input | N_LINES | Raw interrupt line levels, synchronous to clk_i |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDX_W | Index of the acknowledged line |
| trig_we_i | input | 1 | Trigger-mode write enable |
| trig_wdata_i | input | N_LINES | Trigger-mode write data (1 = level) |
| init_i | input | 1 | Initialise pulse |
| mask_i | input | N_LINES | Mask bits, used for status only |
| irr_o | output | N_LINES | Pending request vector |
| trig_o | output | N_LINES | Stored trigger mode |
| status_o | output | 2*N_LINES | Per-line status codes |

## Verification
A directed sequence first exercises each rule on its own: a level line toggling, an edge line rising, then held high, then falling, acknowledges on both kinds of line, an acknowledge that coincides with a rising edge, and initialise pulses with lines held high. These separate "follows the line" from "remembers the edge" and show whether the acknowledge is ordered before the line event. A long pseudo-random sweep follows under three trigger-mode settings: all edge, all writable bits level, and alternating. Lines, acknowledges, masks and initialise pulses vary together in it, so interactions between lines and modes that the directed steps never combine are compared against an arithmetic model every cycle.

// File: rtl/irl_pkg.sv
package irl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_RAISED = 2'b01,
    ST_MASKED = 2'b11
  } irl_stat_e;
endpackage

// File: rtl/irl_ack_dec.sv
module irl_ack_dec #(
  parameter int N_LINES = 8,
  localparam int IDX_W = $clog2(N_LINES)
) (
  input  logic               valid_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [N_LINES-1:0] hit_o
);
  for (genvar i = 0; i < N_LINES; i++) begin : g_hit
    assign hit_o[i] = valid_i && (idx_i == IDX_W'(i));
  end
endmodule

// File: rtl/irl_trig_reg.sv
module irl_trig_reg #(
  parameter int               N_LINES = 8,
  parameter logic [N_LINES-1:0] WMASK = 8'hF8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [N_LINES-1:0] wdata_i,
  output logic [N_LINES-1:0] trig_o
);
  logic [N_LINES-1:0] trig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   trig_q <= '0;
    else if (we_i) trig_q <= wdata_i & WMASK;
  end

  assign trig_o = trig_q;

  a_r7_unwritable_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_q & ~WMASK) == '0);
  a_r7_write_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> trig_q == ($past(wdata_i) & WMASK));
endmodule

// File: rtl/irl_line_cell.sv
module irl_line_cell
  import irl_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  input  logic       level_i,
  input  logic       ack_i,
  input  logic       init_i,
  input  logic       mask_i,
  output logic       irr_o,
  output logic [1:0] stat_o
);
  logic      irr_q, prev_q;
  irl_stat_e stat_q;
  logic      irr_ack, rise, set_evt, new_req, irr_d, prev_d;
  irl_stat_e stat_d;

  always_comb begin
    // acknowledge first, line event after
    irr_ack = irr_q & ~(ack_i & ~level_i);
    rise    = line_i & ~prev_q;
    set_evt = level_i ? line_i : rise;
    if (init_i) begin
      irr_d   = irr_q & level_i;
      prev_d  = 1'b0;
      new_req = 1'b0;
    end else begin
      irr_d   = level_i ? line_i : (irr_ack | rise);
      prev_d  = line_i;
      new_req = set_evt & ~irr_ack;
    end
    if (mask_i)       stat_d = ST_MASKED;
    else if (new_req) stat_d = ST_RAISED;
    else              stat_d = ST_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q  <= 1'b0;
      prev_q <= 1'b0;
      stat_q <= ST_IDLE;
    end else begin
      irr_q  <= irr_d;
      prev_q <= prev_d;
      stat_q <= stat_d;
    end
  end

  assign irr_o  = irr_q;
  assign stat_o = stat_q;

  a_r2_level_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_i && !init_i |=> irr_q == $past(line_i));
  a_r4_edge_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i && !init_i && !ack_i && !(line_i && !prev_q) |=> $stable(irr_q));
  a_r5_edge_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i && !init_i && ack_i && !(line_i && !prev_q) |=> !irr_q);
  a_r6_rise_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !level_i && !init_i && line_i && !prev_q |=> irr_q);
  a_r8_init_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && !level_i |=> !irr_q && !prev_q);
  a_r8_init_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i && level_i |=> $stable(irr_q));
  a_r9_masked_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |=> stat_q == ST_MASKED);
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int                 N_LINES = 8,
  parameter logic [N_LINES-1:0] WMASK   = 8'hF8,
  localparam int                IDX_W   = $clog2(N_LINES)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LINES-1:0]   line_i,
  input  logic                 ack_valid_i,
  input  logic [IDX_W-1:0]     ack_idx_i,
  input  logic                 trig_we_i,
  input  logic [N_LINES-1:0]   trig_wdata_i,
  input  logic                 init_i,
  input  logic [N_LINES-1:0]   mask_i,
  output logic [N_LINES-1:0]   irr_o,
  output logic [N_LINES-1:0]   trig_o,
  output logic [2*N_LINES-1:0] status_o
);
  logic [N_LINES-1:0] ack_hit;
  logic [N_LINES-1:0] trig;

  irl_ack_dec #(.N_LINES(N_LINES)) u_ack_dec (
    .valid_i (ack_valid_i),
    .idx_i   (ack_idx_i),
    .hit_o   (ack_hit)
  );

  irl_trig_reg #(.N_LINES(N_LINES), .WMASK(WMASK)) u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (trig_we_i),
    .wdata_i (trig_wdata_i),
    .trig_o  (trig)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_cell
    irl_line_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .line_i  (line_i[i]),
      .level_i (trig[i]),
      .ack_i   (ack_hit[i]),
      .init_i  (init_i),
      .mask_i  (mask_i[i]),
      .irr_o   (irr_o[i]),
      .stat_o  (status_o[2*i +: 2])
    );
  end

  assign trig_o = trig;

  a_r9_mask_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_i |=> ((irr_o & trig_o) == ($past(line_i) & trig_o)));
endmodule

// File: tb/irq_req_latch_tb.sv
module irq_req_latch_tb;
  localparam int N = 8;
  localparam logic [7:0] WM = 8'hF8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] line_i = '0, trig_wdata_i = '0, mask_i = '0;
  logic ack_valid_i = 1'b0, trig_we_i = 1'b0, init_i = 1'b0;
  logic [2:0] ack_idx_i = '0;
  logic [7:0] irr_o, trig_o;
  logic [15:0] status_o;

  always #10 clk = ~clk;

  irq_req_latch #(.N_LINES(N), .WMASK(WM)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i), .ack_valid_i(ack_valid_i),
    .ack_idx_i(ack_idx_i), .trig_we_i(trig_we_i), .trig_wdata_i(trig_wdata_i),
    .init_i(init_i), .mask_i(mask_i), .irr_o(irr_o), .trig_o(trig_o),
    .status_o(status_o));

  int errors = 0, checks = 0;
  bit done = 1'b0;
  logic [7:0] m_irr = '0, m_prev = '0, m_trig = '0;
  logic [15:0] m_stat = '0;

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input logic [7:0] ln, input logic av, input logic [2:0] ai,
                      input logic we, input logic [7:0] wd, input logic in,
                      input logic [7:0] mk, input string tag);
    line_i = ln; ack_valid_i = av; ack_idx_i = ai; trig_we_i = we;
    trig_wdata_i = wd; init_i = in; mask_i = mk;
    for (int i = 0; i < N; i++) begin
      logic r, nw;
      r = m_irr[i]; nw = 1'b0;
      if (in) begin
        if (!m_trig[i]) r = 1'b0;
        m_prev[i] = 1'b0;
      end else begin
        if (av && ai == 3'(i) && !m_trig[i]) r = 1'b0;
        if (m_trig[i]) begin
          nw = ln[i] && !r;
          r = ln[i];
        end else if (ln[i] && !m_prev[i]) begin
          nw = !r;
          r = 1'b1;
        end
        m_prev[i] = ln[i];
      end
      m_irr[i] = r;
      m_stat[2*i +: 2] = mk[i] ? 2'b11 : (nw ? 2'b01 : 2'b00);
    end
    if (we) m_trig = wd & WM;
    @(posedge clk);
    @(negedge clk);
    chk(tag, "irr", {8'h0, irr_o}, {8'h0, m_irr});
    chk(tag, "trig", {8'h0, trig_o}, {8'h0, m_trig});
    chk(tag, "status", status_o, m_stat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    chk("R1", "irr", {8'h0, irr_o}, 16'h0);
    chk("R1", "trig", {8'h0, trig_o}, 16'h0);
    chk("R1", "status", status_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R7: writable mask
    step(8'h00, 0, 0, 1, 8'hFF, 0, 8'h00, "R7");
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R7");
    // R2: level line 3 follows
    step(8'h08, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    step(8'h08, 1, 3, 0, 8'h00, 0, 8'h00, "R5");
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R2");
    // R3/R4: edge line 0
    step(8'h01, 0, 0, 0, 8'h00, 0, 8'h00, "R3");
    step(8'h01, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    step(8'h01, 1, 0, 0, 8'h00, 0, 8'h00, "R5");
    step(8'h01, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    step(8'h01, 0, 0, 0, 8'h00, 0, 8'h00, "R3");
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    // R6: ack and rising edge together on line 1
    step(8'h02, 0, 0, 0, 8'h00, 0, 8'h00, "R3");
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'h00, "R4");
    step(8'h02, 1, 1, 0, 8'h00, 0, 8'h00, "R6");
    // R8: init with level line 4 and edge lines 1,2 high
    step(8'h16, 0, 0, 0, 8'h00, 0, 8'h00, "R8");
    step(8'h16, 0, 0, 0, 8'h00, 1, 8'h00, "R8");
    step(8'h16, 0, 0, 0, 8'h00, 0, 8'h00, "R8");
    // R9: status codes, mask does not touch irr
    step(8'h00, 0, 0, 0, 8'h00, 0, 8'hFF, "R9");
    step(8'h21, 0, 0, 0, 8'h00, 0, 8'h01, "R9");
    step(8'h21, 0, 0, 0, 8'h00, 0, 8'h00, "R9");

    // sweep under three trigger settings
    foreach (lfsr[k]) if (k < 3) begin
      logic [7:0] tv;
      tv = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'hAA;
      step(8'h00, 0, 0, 1, tv, 1, 8'h00, "R7");
      for (int c = 0; c < 400; c++) begin
        logic [15:0] a;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        a = lfsr ^ 16'(c * 40503);
        step(a[7:0], a[8], a[11:9], 1'b0, 8'h00, (a[15:12] == 4'hF),
             {a[3:0], a[15:12]} & {8{a[14]}}, "R2 R3 R4 R5 R6 R8 R9 sweep");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule